// File: doc/BRIEF.md
# Flash Burst Read Front-End

This block is the read-side control of a partitioned NOR-style flash. It takes the chip-select, address-valid, output-enable and write-enable strobes, a clock-enable that stands for the external burst clock, and an address bus. It returns a data word together with its drive enable, and a WAIT flag together with its own drive enable. Whether data is driven depends on the strobes. WAIT is driven whenever the chip is selected.

Three read behaviours are available. In asynchronous array reads, a transparent address latch closes when address-valid goes high. In synchronous burst reads, the address is captured by whichever comes first: an enabled clock edge while address-valid is low, or the rise of address-valid. A programmable number of clock edges follows, and then the block walks a linearly wrapping burst. Single-word information reads keep WAIT asserted. Stopping the clock with output-enable high suspends a burst. Restarting the clock resumes it at the word where it stopped. A write cycle loads the read mode and the latency. A computed partition array stands in for the flash cells.

Top module: `flash_rd_frontend`

## Requirements
- R1: After reset the block is in asynchronous array mode with latency 4, and a reset issued from any mode returns it to asynchronous array reads.
- R2: `data_oe_o` is 1 exactly when `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. With `ce_ni`=1 it is 0 for any `oe_ni`.
- R3: In asynchronous mode the address follows `addr_i` while `adv_ni` is low and is held once `adv_ni` rises. Changes to `addr_i` after that rise have no effect. `wait_o` is 0 in this mode.
- R4: The array word at address A (8 bits) is {2'b00, A[7:6], 4'hA, 2'b00, A[5:0]}. The upper two address bits select one of four partitions, and exactly one partition is selected.
- R5: A cycle with `ce_ni`=0 and `we_ni`=0 loads the mode from `addr_i[1:0]` (0 async, 1 burst, 2 info, 3 async) and the latency from `addr_i[4:2]`. A latency value below 2 is taken as 2.
- R6: In burst mode, an enabled clock edge while `adv_ni` is low captures `addr_i`. Later `addr_i` changes are ignored, even while `adv_ni` stays low.
- R7: In burst mode, if `adv_ni` rises before any enabled clock edge, that rise captures the address.
- R8: With latency L, `wait_o` is 1 from the start of the access. It falls on the L-th enabled clock edge after the capture, and on that same edge the word at the captured address appears. WAIT falls only on an enabled edge.
- R9: Each further enabled edge advances to the next word, wrapping within the aligned 8-word block.
- R10: With `clk_en_i`=0 and `oe_ni`=1 the burst is suspended. Data is not driven, while WAIT stays driven and keeps its value. The burst position is kept, so after resume the next edge gives the following word.
- R11: A suspend during the initial latency pauses the latency count. WAIT stays 1 and driven, and the first word comes after the remaining edges.
- R12: `wait_oe_o` equals the inverse of `ce_ni`.
- R13: In info mode `wait_o` is 1 while selected. The data is {8'hC3, latched address}, and it does not advance on clock edges.
- R14: Deselecting the chip ends the access. After reselection, no burst runs until a new address-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Burst clock edge qualifier (0 = clock stopped) |
| ce_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Address valid, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low (configuration load) |
| addr_i | input | ADDR_W | Address bus |
| data_o | output | DATA_W | Read data (0 when not driven) |
| data_oe_o | output | 1 | Data bus drive enable |
| wait_o | output | 1 | WAIT, 1 = data not yet valid |
| wait_oe_o | output | 1 | WAIT drive enable |

## Verification
The drive enables follow the strobes within the same cycle. An asynchronous read address shows its word after the first rising edge that samples it. A burst word appears on the L-th enabled edge after the capture edge, and every later enabled edge moves one word on. The bench applies inputs on the falling edge and reads outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. It counts the enabled edges one by one, and checks WAIT on every edge of the latency window, both with and without a suspend in between.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_BURST = 2'd1,
    MODE_INFO  = 2'd2,
    MODE_RSVD  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] INFO_TAG  = 8'hC3;
  localparam logic [3:0] ARRAY_TAG = 4'hA;
  localparam logic [2:0] LAT_RST   = 3'd4;
  localparam logic [2:0] LAT_MIN   = 3'd2;

  function automatic logic [2:0] clamp_lat(input logic [2:0] v);
    return (v < LAT_MIN) ? LAT_MIN : v;
  endfunction
endpackage

// File: rtl/flash_cfg_reg.sv
module flash_cfg_reg
  import flash_rd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [4:0] cfg_i,
  output rd_mode_e   mode_o,
  output logic [2:0] lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_ASYNC;
      lat_o  <= LAT_RST;
    end else if (wr_i) begin
      mode_o <= rd_mode_e'(cfg_i[1:0]);
      lat_o  <= clamp_lat(cfg_i[4:2]);
    end
  end
endmodule

// File: rtl/flash_addr_capture.sv
module flash_addr_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              adv_ni,
  input  logic              clk_en_i,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              new_o,
  output logic              start_o
);
  logic adv_q, pending_q, sel, open_w;

  assign sel     = !ce_ni && we_ni;
  assign new_o   = sel && !adv_ni && adv_q;
  assign open_w  = sel && !adv_ni && (new_o || pending_q);
  // first of: enabled edge while latch open, or address-valid rise
  assign start_o = sync_i && ((open_w && clk_en_i) || (sel && adv_ni && pending_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_q     <= 1'b1;
      pending_q <= 1'b0;
      addr_o    <= '0;
    end else begin
      adv_q <= adv_ni | ce_ni;
      if (!sel) begin
        pending_q <= 1'b0;
      end else if (open_w) begin
        addr_o    <= addr_i;
        pending_q <= !(sync_i && clk_en_i);
      end else if (adv_ni) begin
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq #(
  parameter int BW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          new_i,
  input  logic          step_i,
  input  logic [2:0]    lat_i,
  output logic          active_o,
  output logic          valid_o,
  output logic [2:0]    lat_cnt_o,
  output logic [BW-1:0] offs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      valid_o   <= 1'b0;
      lat_cnt_o <= '0;
      offs_o    <= '0;
    end else if (clr_i) begin
      active_o  <= 1'b0;
      valid_o   <= 1'b0;
      lat_cnt_o <= '0;
      offs_o    <= '0;
    end else if (start_i) begin
      active_o  <= 1'b1;
      valid_o   <= 1'b0;
      lat_cnt_o <= lat_i;
      offs_o    <= '0;
    end else if (new_i) begin
      active_o <= 1'b0;
      valid_o  <= 1'b0;
    end else if (step_i && active_o) begin
      if (!valid_o) begin
        if (lat_cnt_o <= 3'd1) begin
          valid_o   <= 1'b1;
          lat_cnt_o <= '0;
        end else begin
          lat_cnt_o <= lat_cnt_o - 3'd1;
        end
      end else begin
        offs_o <= offs_o + BW'(1);
      end
    end
  end
endmodule

// File: rtl/flash_part_array.sv
module flash_part_array
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PART_W = 2,
  parameter int DATA_W = 16,
  localparam int OFF_W = ADDR_W - PART_W,
  localparam int NPART = 1 << PART_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NPART-1:0]  sel_o,
  output logic [DATA_W-1:0] word_o
);
  logic [NPART-1:0][DATA_W-1:0] words;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    assign sel_o[p] = (addr_i[ADDR_W-1 -: PART_W] == PART_W'(p));
    assign words[p] = sel_o[p] ? DATA_W'({4'(p), ARRAY_TAG, 8'(addr_i[OFF_W-1:0])}) : '0;
  end

  always_comb begin
    word_o = '0;
    for (int p = 0; p < NPART; p++) word_o |= words[p];
  end
endmodule

// File: rtl/flash_rd_frontend.sv
module flash_rd_frontend
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PART_W    = 2,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wait_o,
  output logic              wait_oe_o
);
  localparam int NPART = 1 << PART_W;
  localparam int BW    = $clog2(BURST_LEN);

  rd_mode_e          mode;
  logic [2:0]        lat_cfg, lat_cnt;
  logic              burst_m, info_m, cfg_wr;
  logic [ADDR_W-1:0] addr_q, rd_addr;
  logic              new_acc, start, active, valid;
  logic [BW-1:0]     burst_offs;
  logic [NPART-1:0]  part_sel;
  logic [DATA_W-1:0] arr_word, info_word;

  assign cfg_wr  = !ce_ni && !we_ni;
  assign burst_m = (mode == MODE_BURST);
  assign info_m  = (mode == MODE_INFO);

  flash_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr),
    .cfg_i  (addr_i[4:0]),
    .mode_o (mode),
    .lat_o  (lat_cfg)
  );

  flash_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .adv_ni   (adv_ni),
    .clk_en_i (clk_en_i),
    .sync_i   (burst_m),
    .addr_i   (addr_i),
    .addr_o   (addr_q),
    .new_o    (new_acc),
    .start_o  (start)
  );

  flash_burst_seq #(.BW(BW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ce_ni || !we_ni),
    .start_i   (start),
    .new_i     (new_acc),
    .step_i    (clk_en_i),
    .lat_i     (lat_cfg),
    .active_o  (active),
    .valid_o   (valid),
    .lat_cnt_o (lat_cnt),
    .offs_o    (burst_offs)
  );

  // linear wrap inside the aligned burst block
  assign rd_addr = burst_m ? {addr_q[ADDR_W-1:BW], addr_q[BW-1:0] + burst_offs} : addr_q;

  flash_part_array #(.ADDR_W(ADDR_W), .PART_W(PART_W), .DATA_W(DATA_W)) u_arr (
    .addr_i (rd_addr),
    .sel_o  (part_sel),
    .word_o (arr_word)
  );

  assign info_word = DATA_W'({INFO_TAG, 8'(addr_q)});

  assign data_oe_o = !ce_ni && !oe_ni && we_ni;
  assign data_o    = !data_oe_o ? '0 : (info_m ? info_word : arr_word);
  assign wait_oe_o = !ce_ni;
  assign wait_o    = !ce_ni && (info_m || (burst_m && !valid));
endmodule

// File: rtl/flash_rd_frontend_chk.sv
module flash_rd_frontend_chk #(
  parameter int NPART = 4,
  parameter int BW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             oe_ni,
  input logic             we_ni,
  input logic             adv_ni,
  input logic             clk_en_i,
  input logic             data_oe_o,
  input logic             wait_o,
  input logic             wait_oe_o,
  input logic             info_m,
  input logic [NPART-1:0] part_sel,
  input logic [BW-1:0]    burst_offs,
  input logic [2:0]       lat_cnt,
  input logic             active,
  input logic             valid
);
  AST_BUS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni && we_ni)); // R2

  AST_WAIT_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_oe_o == !ce_ni); // R12

  AST_ONE_PART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(part_sel) == 1); // R4

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && adv_ni && valid && clk_en_i)
      |=> (burst_offs == BW'($past(burst_offs) + BW'(1)))); // R9

  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && adv_ni && !clk_en_i && active)
      |=> ($stable(burst_offs) && $stable(lat_cnt) && $stable(valid))); // R10

  AST_WAIT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && $past(!ce_ni && we_ni) && $fell(wait_o)) |-> $past(clk_en_i)); // R8

  AST_INFO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && info_m) |-> wait_o); // R13
endmodule

bind flash_rd_frontend flash_rd_frontend_chk #(.NPART(NPART), .BW(BW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .we_ni      (we_ni),
  .adv_ni     (adv_ni),
  .clk_en_i   (clk_en_i),
  .data_oe_o  (data_oe_o),
  .wait_o     (wait_o),
  .wait_oe_o  (wait_oe_o),
  .info_m     (info_m),
  .part_sel   (part_sel),
  .burst_offs (burst_offs),
  .lat_cnt    (lat_cnt),
  .active     (active),
  .valid      (valid)
);

// File: tb/flash_rd_frontend_tb.sv
module flash_rd_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0, ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] data;
  logic        data_oe, wt, wt_oe;
  int          tests = 0, fails = 0;

  always #4 clk = ~clk;

  flash_rd_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .ce_ni(ce_n), .adv_ni(adv_n),
    .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .data_o(data), .data_oe_o(data_oe),
    .wait_o(wt), .wait_oe_o(wt_oe)
  );

  // {address, expected word}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 16'h0A00}, {8'h3F, 16'h0A3F}, {8'h40, 16'h1A00}, {8'h7F, 16'h1A3F},
    {8'h95, 16'h2A15}, {8'hC1, 16'h3A01}, {8'hFF, 16'h3A3F}, {8'h2A, 16'h0A2A}
  };

  function automatic logic [15:0] word_of(input logic [7:0] a);
    return {2'b00, a[7:6], 4'hA, 2'b00, a[5:0]};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [2:0] l);
    ce_n = 0; we_n = 0; oe_n = 0; adv_n = 1; clk_en = 0; addr = {3'b000, l, m};
    tick();
    chk("R2 no drive during write", {15'b0, data_oe}, 16'h0);
    we_n = 1; ce_n = 1; oe_n = 1;
    tick();
  endtask

  task automatic async_read(input logic [7:0] a);
    ce_n = 0; oe_n = 0; adv_n = 0; addr = a; clk_en = 0;
    tick();
    adv_n = 1; addr = ~a;
    tick();
  endtask

  initial begin
    #(64'd8 * 64'd200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset data_oe", {15'b0, data_oe}, 16'h0);
    chk("R12 reset wait_oe", {15'b0, wt_oe}, 16'h0);

    // R3 R4: async reads from the vector table
    for (int i = 0; i < 8; i++) begin
      async_read(VEC[i][23:16]);
      chk("R3/R4 async word", data, VEC[i][15:0]);
      chk("R2 drive on", {15'b0, data_oe}, 16'h1);
      chk("R3 no wait async", {15'b0, wt}, 16'h0);
      ce_n = 1; oe_n = 1;
      tick();
      chk("R2 deselect no drive", {15'b0, data_oe}, 16'h0);
    end

    ce_n = 0; oe_n = 1; adv_n = 1;
    tick();
    chk("R2 oe high no drive", {15'b0, data_oe}, 16'h0);
    chk("R12 wait driven", {15'b0, wt_oe}, 16'h1);
    ce_n = 1;
    tick();

    // burst, latency 3, capture by edge after adv fall
    cfg(2'd1, 3'd3);
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 8'h45; clk_en = 0;
    tick();
    chk("R8 wait at access start", {15'b0, wt}, 16'h1);
    clk_en = 1;
    tick();
    chk("R8 wait at capture", {15'b0, wt}, 16'h1);
    adv_n = 1; addr = 8'h00;
    tick(); chk("R8 wait e1", {15'b0, wt}, 16'h1);
    tick(); chk("R8 wait e2", {15'b0, wt}, 16'h1);
    tick();
    chk("R8 wait falls e3", {15'b0, wt}, 16'h0);
    chk("R8 first word", data, word_of(8'h45));
    tick(); chk("R9 word 2", data, word_of(8'h46));
    tick(); chk("R9 word 3", data, word_of(8'h47));
    tick(); chk("R9 wrap", data, word_of(8'h40));
    tick(); chk("R9 word 5", data, word_of(8'h41));
    clk_en = 0; oe_n = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 suspend no drive", {15'b0, data_oe}, 16'h0);
      chk("R10 suspend wait driven", {15'b0, wt_oe}, 16'h1);
      chk("R10 suspend wait held", {15'b0, wt}, 16'h0);
    end
    oe_n = 0;
    tick(); chk("R10 position kept", data, word_of(8'h41));
    clk_en = 1;
    tick(); chk("R10 resume next", data, word_of(8'h42));
    ce_n = 1; clk_en = 0;
    tick();
    chk("R14 wait released", {15'b0, wt_oe}, 16'h0);
    chk("R14 data released", {15'b0, data_oe}, 16'h0);
    ce_n = 0;
    tick();
    chk("R14 no burst after reselect", {15'b0, wt}, 16'h1);
    chk("R12 wait driven again", {15'b0, wt_oe}, 16'h1);
    ce_n = 1;
    tick();

    // R7 R11: capture by adv rise, suspend inside latency
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 8'h9E; clk_en = 0;
    tick();
    adv_n = 1; addr = 8'h00;
    tick();
    clk_en = 1;
    tick(); chk("R11 wait e1", {15'b0, wt}, 16'h1);
    clk_en = 0; oe_n = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R11 wait held in latency", {15'b0, wt}, 16'h1);
      chk("R11 wait driven", {15'b0, wt_oe}, 16'h1);
    end
    oe_n = 0; clk_en = 1;
    tick(); chk("R11 wait e2", {15'b0, wt}, 16'h1);
    tick();
    chk("R11 wait falls e3", {15'b0, wt}, 16'h0);
    chk("R7 adv-rise address", data, word_of(8'h9E));
    tick(); chk("R9 word 2b", data, word_of(8'h9F));
    tick(); chk("R9 wrap b", data, word_of(8'h98));
    ce_n = 1; clk_en = 0;
    tick();

    // R6: edge capture, later address ignored while adv low
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 8'h10; clk_en = 1;
    tick();
    addr = 8'h33;
    tick();
    adv_n = 1;
    tick();
    tick();
    chk("R6 wait done", {15'b0, wt}, 16'h0);
    chk("R6 edge-captured address", data, word_of(8'h10));
    ce_n = 1; clk_en = 0;
    tick();

    // R5: latency clamp to 2
    cfg(2'd1, 3'd1);
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 8'hC7; clk_en = 1;
    tick();
    adv_n = 1;
    tick(); chk("R5 clamp wait e1", {15'b0, wt}, 16'h1);
    tick();
    chk("R5 clamp wait e2", {15'b0, wt}, 16'h0);
    chk("R5 clamp word", data, word_of(8'hC7));
    ce_n = 1; clk_en = 0;
    tick();

    // R8: latency 7
    cfg(2'd1, 3'd7);
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 8'h6B; clk_en = 1;
    tick();
    adv_n = 1;
    for (int k = 1; k < 7; k++) begin
      tick();
      chk("R8 lat7 wait", {15'b0, wt}, 16'h1);
    end
    tick();
    chk("R8 lat7 wait falls", {15'b0, wt}, 16'h0);
    chk("R8 lat7 word", data, word_of(8'h6B));
    ce_n = 1; clk_en = 0;
    tick();

    // R13: info reads
    cfg(2'd2, 3'd3);
    async_read(8'h27);
    chk("R13 info word", data, 16'hC327);
    chk("R13 info wait", {15'b0, wt}, 16'h1);
    clk_en = 1;
    tick(); tick();
    chk("R13 no advance", data, 16'hC327);
    chk("R13 wait kept", {15'b0, wt}, 16'h1);
    ce_n = 1; clk_en = 0;
    tick();

    // R5: reserved mode behaves as async
    cfg(2'd3, 3'd0);
    async_read(8'h40);
    chk("R5 mode3 async word", data, 16'h1A00);
    chk("R5 mode3 no wait", {15'b0, wt}, 16'h0);
    ce_n = 1;
    tick();

    // R1: reset from burst mode returns to async
    cfg(2'd1, 3'd4);
    rst_n = 0;
    tick();
    rst_n = 1;
    tick();
    async_read(8'h7F);
    chk("R1 async after reset", data, word_of(8'h7F));
    chk("R1 no wait after reset", {15'b0, wt}, 16'h0);
    ce_n = 1;
    tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule